// File: doc/BRIEF.md
# Flash Write-Protection Arbiter

This block sits between the command decoder of a 1024-sector serial NOR flash and the program/erase engine. For each finished command frame it answers one question: may this operation go ahead? It holds the write-enable latch, a write-lock bit and a lock-down bit for every sector, and a status-register protection field: a 4-bit region size plus a direction bit that picks the bottom or the top of the array. The answer is a one-cycle allow or deny pulse. A deny pulse carries a reason code.

The decoder presents a strobe at chip-select release. With the strobe come a command class, the target sector, the number of serial clocks in the frame, and the data for a lock or status write. When a lock-register write is granted, the sector's two lock bits are updated. When a status write is granted, the protection field is updated. All three outputs are registered, so the decision appears on the cycle after the strobe.

Top module: `flash_write_guard`

## Requirements
- R1: A modifying command (class 1 program, 2 erase, 3 status write, 4 lock write) whose clock count is not a multiple of 8 is denied with reason 0, and it changes no lock or status state.
- R2: Class 0 (write enable) is always allowed and sets `wel_o`. A modifying command with a whole frame issued while `wel_o` is 0 is denied with reason 1.
- R3: After any modifying command, allowed or denied, `wel_o` reads 0.
- R4: With `tb_o`=0 and protect value n≥1, the top 2^(n-1) sectors are protected, and every sector is protected once 2^(n-1) ≥ 1024. With n=0 nothing is protected. A program or erase to a protected sector is denied with reason 2.
- R5: With `tb_o`=1, the region of the same size starts at sector 0 and grows upward.
- R6: A granted lock write stores `lock_data_i[0]` as the sector's write-lock bit and `lock_data_i[1]` as its lock-down bit. A program or erase to a write-locked sector is denied with reason 3. Clearing the write-lock bit re-enables the sector.
- R7: A lock write to a sector whose lock-down bit is set is denied with reason 3, and the sector's bits stay as they were until reset.
- R8: When more than one fault applies, the reason follows this priority: framing (0), then latch (1), then block protect (2), then sector lock (3).
- R9: Each command of class 0 to 4 gives exactly one of `allow_o` or `deny_o`, one cycle after `cmd_valid_i`. Classes 5 to 7 and idle cycles give no pulse and change no state.
- R10: Reset clears the latch, all lock bits, all lock-down bits and the protection field.
- R11: A granted status write loads `status_data_i[3:0]` into the protect value and `status_data_i[4]` into the direction bit. Status and lock writes are not subject to block protect.
- R12: A program or erase with a whole frame, the latch set, and a target sector that is neither protected nor locked is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | One-cycle strobe at chip-select release |
| cmd_class_i | input | 3 | Command class (0 write enable, 1 program, 2 erase, 3 status write, 4 lock write) |
| sector_i | input | SEC_W (10) | Target sector index |
| clk_count_i | input | CNT_W (16) | Serial clocks counted in the frame |
| lock_data_i | input | 2 | Lock write data: bit 1 lock-down, bit 0 write-lock |
| status_data_i | input | 5 | Status write data: bit 4 direction, bits 3:0 protect value |
| allow_o | output | 1 | Command granted (one-cycle pulse) |
| deny_o | output | 1 | Command refused (one-cycle pulse) |
| deny_code_o | output | 2 | Reason while `deny_o` is high, otherwise 0 |
| wel_o | output | 1 | Write-enable latch |
| bp_o | output | 4 | Protect value |
| tb_o | output | 1 | Region direction (1 = bottom) |

## Verification
Several refusal conditions can apply to the same command in the same cycle. The clearest cases are a sector that is both inside the block-protect region and write-locked, and a truncated frame sent while the latch is clear. The bench sets up both overlaps on purpose. It locks a sector that lies inside a bottom region and then programs it, and it sends a 31-clock program right after a command that cleared the latch. A single deny pulse must appear, and the reason code must follow the priority in R8. The latch clear that happens in the same cycle as the decision is then confirmed through `wel_o`.

// File: rtl/fwg_pkg.sv
`timescale 1ns/1ps
package fwg_pkg;
  typedef enum logic [2:0] {
    CMD_WREN      = 3'd0,
    CMD_PROG      = 3'd1,
    CMD_ERASE     = 3'd2,
    CMD_STATUS_WR = 3'd3,
    CMD_LOCK_WR   = 3'd4
  } fwg_cmd_e;

  typedef enum logic [1:0] {
    WHY_FRAME       = 2'd0,
    WHY_NO_WEL      = 2'd1,
    WHY_BLOCK_PROT  = 2'd2,
    WHY_SECTOR_LOCK = 2'd3
  } fwg_why_e;
endpackage

// File: rtl/fwg_lock_bank.sv
`timescale 1ns/1ps
module fwg_lock_bank #(
  parameter int SEC_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEC_W-1:0] idx,
  input  logic [1:0]       wr_data,
  output logic             rd_lock,
  output logic             rd_down
);
  localparam int NUM_SEC = 1 << SEC_W;

  logic [NUM_SEC-1:0] lock_v;
  logic [NUM_SEC-1:0] down_v;

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    logic lk_q;
    logic dn_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lk_q <= 1'b0;
        dn_q <= 1'b0;
      end else if (wr_en && idx == SEC_W'(s)) begin
        lk_q <= wr_data[0];
        dn_q <= wr_data[1];
      end
    end
    assign lock_v[s] = lk_q;
    assign down_v[s] = dn_q;

    // once frozen, the sector stays frozen until reset
    p_lockdown_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dn_q |=> dn_q);
    p_lock_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dn_q |=> $stable(lk_q));
  end

  assign rd_lock = lock_v[idx];
  assign rd_down = down_v[idx];
endmodule

// File: rtl/fwg_decide.sv
`timescale 1ns/1ps
module fwg_decide
  import fwg_pkg::*;
#(
  parameter int SEC_W = 10,
  parameter int CNT_W = 16
) (
  input  fwg_cmd_e         cls,
  input  logic [CNT_W-1:0] clk_count,
  input  logic [SEC_W-1:0] sector,
  input  logic             wel,
  input  logic [3:0]       bp,
  input  logic             tb,
  input  logic             sec_lock,
  input  logic             sec_down,
  output logic             is_mod,
  output logic             frame_ok,
  output logic             bp_hit,
  output logic             lock_hit,
  output logic             grant,
  output fwg_why_e         why
);
  localparam int EW = SEC_W + 1;

  function automatic logic frame_whole(input logic [CNT_W-1:0] n);
    return (n & CNT_W'(7)) == '0;
  endfunction

  // region of 2^(bp-1) sectors at the top (tb=0) or bottom (tb=1)
  function automatic logic bp_covers(input logic [SEC_W-1:0] s,
                                     input logic [3:0] v, input logic dir);
    logic [EW-1:0] span;
    logic [EW-1:0] ext;
    int sh;
    ext = {1'b0, s};
    if (v == 4'd0) return 1'b0;
    sh = 32'(v) - 1;
    if (sh >= SEC_W) return 1'b1;
    span = EW'(1) << sh;
    if (dir) return ext < span;
    return ext >= ((EW'(1) << SEC_W) - span);
  endfunction

  logic is_array;

  always_comb begin
    is_array = (cls == CMD_PROG) || (cls == CMD_ERASE);
    is_mod   = is_array || (cls == CMD_STATUS_WR) || (cls == CMD_LOCK_WR);
    frame_ok = frame_whole(clk_count);
    bp_hit   = is_array && bp_covers(sector, bp, tb);
    lock_hit = (is_array && sec_lock) || ((cls == CMD_LOCK_WR) && sec_down);
    grant    = is_mod && frame_ok && wel && !bp_hit && !lock_hit;
    if (!frame_ok)   why = WHY_FRAME;
    else if (!wel)   why = WHY_NO_WEL;
    else if (bp_hit) why = WHY_BLOCK_PROT;
    else             why = WHY_SECTOR_LOCK;
  end
endmodule

// File: rtl/flash_write_guard.sv
`timescale 1ns/1ps
module flash_write_guard
  import fwg_pkg::*;
#(
  parameter int SEC_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_class_i,
  input  logic [SEC_W-1:0] sector_i,
  input  logic [CNT_W-1:0] clk_count_i,
  input  logic [1:0]       lock_data_i,
  input  logic [4:0]       status_data_i,
  output logic             allow_o,
  output logic             deny_o,
  output logic [1:0]       deny_code_o,
  output logic             wel_o,
  output logic [3:0]       bp_o,
  output logic             tb_o
);
  fwg_cmd_e cls_w;
  fwg_why_e why_w;
  fwg_why_e code_q;
  logic is_mod_w, frame_ok_w, bp_hit_w, lock_hit_w, grant_w;
  logic sec_lock_w, sec_down_w, lock_we_w;
  logic allow_q, deny_q, wel_q, tb_q;
  logic [3:0] bp_q;

  assign cls_w = fwg_cmd_e'(cmd_class_i);

  fwg_decide #(.SEC_W(SEC_W), .CNT_W(CNT_W)) i_decide (
    .cls(cls_w), .clk_count(clk_count_i), .sector(sector_i), .wel(wel_q),
    .bp(bp_q), .tb(tb_q), .sec_lock(sec_lock_w), .sec_down(sec_down_w),
    .is_mod(is_mod_w), .frame_ok(frame_ok_w), .bp_hit(bp_hit_w),
    .lock_hit(lock_hit_w), .grant(grant_w), .why(why_w)
  );

  assign lock_we_w = cmd_valid_i && grant_w && (cls_w == CMD_LOCK_WR);

  fwg_lock_bank #(.SEC_W(SEC_W)) i_locks (
    .clk(clk), .rst_n(rst_n), .wr_en(lock_we_w), .idx(sector_i),
    .wr_data(lock_data_i), .rd_lock(sec_lock_w), .rd_down(sec_down_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      allow_q <= 1'b0;
      deny_q  <= 1'b0;
      code_q  <= WHY_FRAME;
      wel_q   <= 1'b0;
      bp_q    <= 4'd0;
      tb_q    <= 1'b0;
    end else begin
      allow_q <= 1'b0;
      deny_q  <= 1'b0;
      code_q  <= WHY_FRAME;
      if (cmd_valid_i) begin
        if (cls_w == CMD_WREN) begin
          allow_q <= 1'b1;
          wel_q   <= 1'b1;
        end else if (is_mod_w) begin
          wel_q <= 1'b0;
          if (grant_w) begin
            allow_q <= 1'b1;
          end else begin
            deny_q <= 1'b1;
            code_q <= why_w;
          end
          if (grant_w && cls_w == CMD_STATUS_WR) begin
            tb_q <= status_data_i[4];
            bp_q <= status_data_i[3:0];
          end
        end
      end
    end
  end

  assign allow_o     = allow_q;
  assign deny_o      = deny_q;
  assign deny_code_o = code_q;
  assign wel_o       = wel_q;
  assign bp_o        = bp_q;
  assign tb_o        = tb_q;

  p_frame_deny_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && is_mod_w && !frame_ok_w |=> deny_o && deny_code_o == WHY_FRAME);
  p_wel_deny_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && is_mod_w && frame_ok_w && !wel_o |=> deny_o && deny_code_o == WHY_NO_WEL);
  p_wren_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && cls_w == CMD_WREN |=> wel_o && allow_o);
  p_wel_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && is_mod_w |=> !wel_o);
  p_bp_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_i && frame_ok_w && wel_o && bp_hit_w |=> deny_o && deny_code_o == WHY_BLOCK_PROT);
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(allow_o && deny_o));
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (allow_o || deny_o) |-> $past(cmd_valid_i));
  p_status_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_i && grant_w && cls_w == CMD_STATUS_WR) |=> $stable(bp_o) && $stable(tb_o));
endmodule

// File: tb/test_flash_write_guard.sv
`timescale 1ns/1ps
module test_flash_write_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_class = 3'd0;
  logic [9:0] sector = 10'd0;
  logic [15:0] clk_count = 16'd0;
  logic [1:0] lock_data = 2'd0;
  logic [4:0] status_data = 5'd0;
  logic allow, deny, wel, tb;
  logic [1:0] deny_code;
  logic [3:0] bp;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_write_guard i_flash_write_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_class_i(cmd_class),
    .sector_i(sector), .clk_count_i(clk_count), .lock_data_i(lock_data),
    .status_data_i(status_data), .allow_o(allow), .deny_o(deny),
    .deny_code_o(deny_code), .wel_o(wel), .bp_o(bp), .tb_o(tb)
  );

  typedef struct packed {
    logic        wren_first;
    logic [2:0]  cls;
    logic [9:0]  sec;
    logic [15:0] cnt;
    logic [4:0]  wd;
    logic        exp_allow;
    logic [1:0]  exp_code;
    logic [3:0]  req;
  } vec_t;

  // outcome: 4'b1000 allow, 4'b01cc deny with reason cc
  localparam vec_t VECS [0:27] = '{
    '{1'b0, 3'd1, 10'd5,    16'd32, 5'd0,  1'b0, 2'd1, 4'd2},  // R2 no latch
    '{1'b1, 3'd1, 10'd5,    16'd33, 5'd0,  1'b0, 2'd0, 4'd1},  // R1 ragged frame
    '{1'b1, 3'd1, 10'd5,    16'd40, 5'd0,  1'b1, 2'd0, 4'd12}, // R12 clean program
    '{1'b0, 3'd2, 10'd5,    16'd32, 5'd0,  1'b0, 2'd1, 4'd3},  // R3 latch consumed
    '{1'b1, 3'd3, 10'd0,    16'd16, 5'd3,  1'b1, 2'd0, 4'd11}, // R11 top 4 sectors
    '{1'b1, 3'd1, 10'd1019, 16'd32, 5'd0,  1'b1, 2'd0, 4'd4},  // R4 just below
    '{1'b1, 3'd1, 10'd1020, 16'd32, 5'd0,  1'b0, 2'd2, 4'd4},  // R4 region edge
    '{1'b1, 3'd2, 10'd1023, 16'd32, 5'd0,  1'b0, 2'd2, 4'd4},  // R4 last sector
    '{1'b1, 3'd3, 10'd0,    16'd16, 5'd21, 1'b1, 2'd0, 4'd11}, // R11 bottom 16
    '{1'b1, 3'd1, 10'd15,   16'd32, 5'd0,  1'b0, 2'd2, 4'd5},  // R5 edge inside
    '{1'b1, 3'd1, 10'd16,   16'd32, 5'd0,  1'b1, 2'd0, 4'd5},  // R5 edge outside
    '{1'b1, 3'd4, 10'd100,  16'd24, 5'd1,  1'b1, 2'd0, 4'd6},  // R6 lock sector
    '{1'b1, 3'd1, 10'd100,  16'd32, 5'd0,  1'b0, 2'd3, 4'd6},  // R6 locked
    '{1'b1, 3'd4, 10'd100,  16'd24, 5'd0,  1'b1, 2'd0, 4'd6},  // R6 unlock
    '{1'b1, 3'd1, 10'd100,  16'd32, 5'd0,  1'b1, 2'd0, 4'd6},  // R6 reopened
    '{1'b1, 3'd4, 10'd200,  16'd24, 5'd3,  1'b1, 2'd0, 4'd7},  // R7 lock+freeze
    '{1'b1, 3'd4, 10'd200,  16'd24, 5'd0,  1'b0, 2'd3, 4'd7},  // R7 unlock refused
    '{1'b1, 3'd2, 10'd200,  16'd32, 5'd0,  1'b0, 2'd3, 4'd7},  // R7 still locked
    '{1'b1, 3'd4, 10'd10,   16'd24, 5'd1,  1'b1, 2'd0, 4'd11}, // R11 lock in region
    '{1'b1, 3'd1, 10'd10,   16'd32, 5'd0,  1'b0, 2'd2, 4'd8},  // R8 bp over lock
    '{1'b0, 3'd1, 10'd10,   16'd31, 5'd0,  1'b0, 2'd0, 4'd8},  // R8 frame over latch
    '{1'b1, 3'd3, 10'd0,    16'd16, 5'd12, 1'b1, 2'd0, 4'd11}, // R11 all protected
    '{1'b1, 3'd1, 10'd0,    16'd32, 5'd0,  1'b0, 2'd2, 4'd4},  // R4 capped
    '{1'b1, 3'd3, 10'd0,    16'd16, 5'd0,  1'b1, 2'd0, 4'd11}, // R11 status ignores bp
    '{1'b1, 3'd1, 10'd0,    16'd32, 5'd0,  1'b1, 2'd0, 4'd4},  // R4 none protected
    '{1'b0, 3'd0, 10'd0,    16'd8,  5'd0,  1'b1, 2'd0, 4'd2},  // R2 write enable
    '{1'b0, 3'd3, 10'd0,    16'd12, 5'd7,  1'b0, 2'd0, 4'd1},  // R1 ragged status
    '{1'b0, 3'd1, 10'd1,    16'd32, 5'd0,  1'b0, 2'd1, 4'd3}   // R3 latch consumed
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [2:0] c, input logic [9:0] s,
                         input logic [15:0] n, input logic [4:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_class = c; sector = s; clk_count = n;
    lock_data = w[1:0]; status_data = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [3:0] outcome();
    return {allow, deny, deny_code};
  endfunction

  task automatic wren();
    run_cmd(3'd0, 10'd0, 16'd8, 5'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {28'd0, outcome()}, 32'd0);
    check("R10 reset latch", {31'd0, wel}, 32'd0);
    check("R10 reset protect", {27'd0, tb, bp}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 28; i++) begin
      if (VECS[i].wren_first) wren();
      run_cmd(VECS[i].cls, VECS[i].sec, VECS[i].cnt, VECS[i].wd);
      check($sformatf("R%0d vec %0d", VECS[i].req, i), {28'd0, outcome()},
            VECS[i].exp_allow ? 32'd8 : {28'd0, 2'b01, VECS[i].exp_code});
    end

    // R2 latch set by write enable; R9 idle cycle gives no pulse
    wren();
    check("R2 latch set", {31'd0, wel}, 32'd1);
    @(negedge clk);
    check("R9 idle no pulse", {28'd0, outcome()}, 32'd0);
    // R9 undefined class: no pulse, latch untouched
    run_cmd(3'd7, 10'd2, 16'd8, 5'd31);
    check("R9 undefined class", {28'd0, outcome()}, 32'd0);
    check("R9 latch kept", {31'd0, wel}, 32'd1);
    check("R9 status kept", {27'd0, tb, bp}, 32'd0);
    run_cmd(3'd1, 10'd2, 16'd8, 5'd0);
    check("R12 program after idle", {28'd0, outcome()}, 32'd8);
    check("R3 latch cleared on allow", {31'd0, wel}, 32'd0);

    // R4 half-array boundary and cap
    wren(); run_cmd(3'd3, 10'd0, 16'd16, 5'd10);
    check("R11 protect value loaded", {27'd0, tb, bp}, 32'd10);
    wren(); run_cmd(3'd1, 10'd511, 16'd8, 5'd0);
    check("R4 sector 511 open", {28'd0, outcome()}, 32'd8);
    wren(); run_cmd(3'd1, 10'd512, 16'd8, 5'd0);
    check("R4 sector 512 protected", {28'd0, outcome()}, 32'd6);
    wren(); run_cmd(3'd3, 10'd0, 16'd16, 5'd11);
    wren(); run_cmd(3'd2, 10'd0, 16'd8, 5'd0);
    check("R4 value 11 covers all", {28'd0, outcome()}, 32'd6);
    // R1 ragged status write leaves field alone
    wren(); run_cmd(3'd3, 10'd0, 16'd9, 5'd0);
    check("R1 status unchanged", {27'd0, tb, bp}, 32'd11);

    // R10 reset releases frozen sector and clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R10 latch after reset", {31'd0, wel}, 32'd0);
    check("R10 protect after reset", {27'd0, tb, bp}, 32'd0);
    rst_n = 1'b1;
    wren(); run_cmd(3'd4, 10'd200, 16'd8, 5'd0);
    check("R10 lock-down cleared", {28'd0, outcome()}, 32'd8);
    wren(); run_cmd(3'd1, 10'd10, 16'd8, 5'd0);
    check("R10 write-lock cleared", {28'd0, outcome()}, 32'd8);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule